// File: doc/BRIEF.md
# Serial EEPROM Status and Write Protection Unit

This block holds the status register of a small serial EEPROM and decides, in the cycle a write request is presented, whether the memory array or the status register may be changed. The SPI front end decodes each instruction and raises a one-cycle strobe when it completes: set-enable, clear-enable, status write or array write. With the strobe come the status data byte or the target byte address. The write engine reports a busy flag, and an active-low write-protect pin qualifies changes to the lock bits.

The unit returns the status byte for status reads. It also drives a single-cycle permit for the array write and another for the status update. A write enable latch must be set before any modifying instruction is honoured. Two block-protect bits fence off the top quarter, the top half or all of the array. A lock bit, combined with the protect pin, freezes the lock and block-protect bits. The address width is a parameter: 13 bits for an 8 KiB array, 12 bits for 4 KiB. The protected ranges scale with it.

Top module: `eeprom_status_guard`

## Requirements
- R1: The status byte holds the lock bit at bit 7, zeros at bits 6 to 4, the block-protect code at bits 3:2, the write enable latch at bit 1 and the busy flag input at bit 0.
- R2: An idle set-enable strobe sets the write enable latch, seen in the status byte from the next cycle.
- R3: An idle clear-enable, status write or array write strobe clears the latch from the next cycle, even when the write itself is refused. A clearing strobe wins over a set-enable strobe in the same cycle.
- R4: arrayWritePermit is 1 in the cycle of an array write strobe only if the latch is set, the engine is idle and the address is outside the protected range.
- R5: Block-protect code 00 protects nothing, 01 the top quarter, 10 the top half and 11 the whole array. With ADDR_W=13 these are 1800h-1FFFh, 1000h-1FFFh and 0000h-1FFFh. With ADDR_W=12 they are 0C00h-0FFFh, 0800h-0FFFh and 0000h-0FFFh.
- R6: An idle status write with the latch set, outside hardware protection, raises statusWritePermit and loads data bits 7, 3 and 2 into the register on the next edge. Data bits 6 to 4, 1 and 0 are ignored.
- R7: Hardware protection holds while the lock bit is 1 and wpN is 0. In that state a status write is refused and bits 7, 3 and 2 do not change. wpN has no effect on array writes.
- R8: While engineBusy is 1, every strobe is ignored: no permit is raised and the latch keeps its value.
- R9: Reset clears the whole status register to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cmdSetEnable | input | 1 | Set-enable instruction completed |
| cmdClearEnable | input | 1 | Clear-enable instruction completed |
| cmdStatusWrite | input | 1 | Status write instruction completed |
| statusDataIn | input | 8 | Data byte of the status write |
| cmdArrayWrite | input | 1 | Array write instruction completed |
| writeAddr | input | ADDR_W | Target byte address of the array write |
| wpN | input | 1 | Write-protect pin, active low |
| engineBusy | input | 1 | Write engine busy |
| statusByte | output | 8 | Status register read value |
| arrayWritePermit | output | 1 | Array write may start |
| statusWritePermit | output | 1 | Status register is updated |

## Verification
The bench probes the addresses on each side of every protected boundary, for both address widths. A wrong decode would either refuse the last free byte or let the first locked byte through. It sends status writes with every don't-care bit set, which would expose a register that stores them. It sends a status write under hardware protection, which a broken lock would apply. It also checks that refused writes and conflicting strobes still leave the latch clear, and that strobes during a busy engine leave the latch exactly where it was.

// File: rtl/eeprom_guard_pkg.sv
package eeprom_guard_pkg;

  typedef struct packed {
    logic setWel;
    logic clearWel;
    logic loadStatus;
    logic permitArray;
  } ctrlStrobes_t;

  localparam int STATUS_W = 8;

endpackage

// File: rtl/eeprom_guard_ctrl.sv
module eeprom_guard_ctrl
  import eeprom_guard_pkg::*;
(
  input  logic         cmdSetEnable,
  input  logic         cmdClearEnable,
  input  logic         cmdStatusWrite,
  input  logic         cmdArrayWrite,
  input  logic         engineBusy,
  input  logic         wpN,
  input  logic         welQ,
  input  logic         lockQ,
  input  logic         addrProtected,
  output ctrlStrobes_t strb
);

  logic idle;
  logic anyClear;
  logic hwLocked;

  always_comb begin
    idle     = !engineBusy;
    anyClear = cmdClearEnable | cmdStatusWrite | cmdArrayWrite;
    hwLocked = lockQ & !wpN;

    strb.setWel      = idle & cmdSetEnable & !anyClear;
    strb.clearWel    = idle & anyClear;
    strb.loadStatus  = idle & cmdStatusWrite & welQ & !hwLocked;
    strb.permitArray = idle & cmdArrayWrite & welQ & !addrProtected;
  end

endmodule

// File: rtl/eeprom_guard_dp.sv
module eeprom_guard_dp
  import eeprom_guard_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  input  logic                newLock,
  input  logic [1:0]          newBp,
  input  logic [ADDR_W-1:0]   writeAddr,
  input  logic                engineBusy,
  output logic                welQ,
  output logic                lockQ,
  output logic                addrProtected,
  output logic [STATUS_W-1:0] statusByte
);

  localparam int TOP = ADDR_W - 1;

  logic [1:0] bpQ;
  logic       topQuarter;
  logic       topHalf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welQ <= 1'b0;
    end else if (strb.clearWel) begin
      welQ <= 1'b0;
    end else if (strb.setWel) begin
      welQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= 1'b0;
      bpQ   <= 2'b00;
    end else if (strb.loadStatus) begin
      lockQ <= newLock;
      bpQ   <= newBp;
    end
  end

  always_comb begin
    topHalf    = writeAddr[TOP];
    topQuarter = writeAddr[TOP] & writeAddr[TOP-1];
    unique case (bpQ)
      2'b00:   addrProtected = 1'b0;
      2'b01:   addrProtected = topQuarter;
      2'b10:   addrProtected = topHalf;
      default: addrProtected = 1'b1;
    endcase
  end

  assign statusByte = {lockQ, 3'b000, bpQ, welQ, engineBusy};

endmodule

// File: rtl/eeprom_status_guard.sv
module eeprom_status_guard
  import eeprom_guard_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdSetEnable,
  input  logic              cmdClearEnable,
  input  logic              cmdStatusWrite,
  input  logic [7:0]        statusDataIn,
  input  logic              cmdArrayWrite,
  input  logic [ADDR_W-1:0] writeAddr,
  input  logic              wpN,
  input  logic              engineBusy,
  output logic [7:0]        statusByte,
  output logic              arrayWritePermit,
  output logic              statusWritePermit
);

  ctrlStrobes_t strb;
  logic         welQ;
  logic         lockQ;
  logic         addrProtected;
  logic [4:0]   unusedDataBits;

  assign unusedDataBits = {statusDataIn[6:4], statusDataIn[1:0]};

  eeprom_guard_ctrl u_ctrl (
    .cmdSetEnable  (cmdSetEnable),
    .cmdClearEnable(cmdClearEnable),
    .cmdStatusWrite(cmdStatusWrite),
    .cmdArrayWrite (cmdArrayWrite),
    .engineBusy    (engineBusy),
    .wpN           (wpN),
    .welQ          (welQ),
    .lockQ         (lockQ),
    .addrProtected (addrProtected),
    .strb          (strb)
  );

  eeprom_guard_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .newLock      (statusDataIn[7]),
    .newBp        (statusDataIn[3:2]),
    .writeAddr    (writeAddr),
    .engineBusy   (engineBusy),
    .welQ         (welQ),
    .lockQ        (lockQ),
    .addrProtected(addrProtected),
    .statusByte   (statusByte)
  );

  assign arrayWritePermit  = strb.permitArray;
  assign statusWritePermit = strb.loadStatus;

endmodule

// File: rtl/eeprom_status_guard_chk.sv
module eeprom_status_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdSetEnable,
  input logic       cmdClearEnable,
  input logic       cmdStatusWrite,
  input logic [7:0] statusDataIn,
  input logic       cmdArrayWrite,
  input logic       wpN,
  input logic       engineBusy,
  input logic [7:0] statusByte,
  input logic       arrayWritePermit,
  input logic       statusWritePermit
);

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[6:4] == 3'b000);

  // R2
  wel_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdSetEnable && !engineBusy && !cmdClearEnable && !cmdStatusWrite && !cmdArrayWrite)
    |=> statusByte[1]);

  // R3
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdClearEnable || cmdStatusWrite || cmdArrayWrite) && !engineBusy) |=> !statusByte[1]);

  // R4
  array_permit_chk: assert property (@(posedge clk) disable iff (!rstN)
    arrayWritePermit |-> (cmdArrayWrite && !engineBusy && statusByte[1]));

  // R5
  whole_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    arrayWritePermit |-> (statusByte[3:2] != 2'b11));

  // R6
  status_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWritePermit |=> (statusByte[7] == $past(statusDataIn[7]) &&
                           statusByte[3:2] == $past(statusDataIn[3:2])));

  // R7
  hw_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWritePermit |-> !(statusByte[7] && !wpN));

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statusWritePermit |=> $stable({statusByte[7], statusByte[3:2]}));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    engineBusy |=> $stable(statusByte[1]));

  // R8
  busy_permit_chk: assert property (@(posedge clk) disable iff (!rstN)
    engineBusy |-> (!arrayWritePermit && !statusWritePermit));

endmodule

bind eeprom_status_guard eeprom_status_guard_chk u_chk (
  .clk              (clk),
  .rstN             (rstN),
  .cmdSetEnable     (cmdSetEnable),
  .cmdClearEnable   (cmdClearEnable),
  .cmdStatusWrite   (cmdStatusWrite),
  .statusDataIn     (statusDataIn),
  .cmdArrayWrite    (cmdArrayWrite),
  .wpN              (wpN),
  .engineBusy       (engineBusy),
  .statusByte       (statusByte),
  .arrayWritePermit (arrayWritePermit),
  .statusWritePermit(statusWritePermit)
);

// File: tb/eeprom_status_guard_tb.sv
`timescale 1ns/100ps
module eeprom_status_guard_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdSetEnable = 1'b0;
  logic        cmdClearEnable = 1'b0;
  logic        cmdStatusWrite = 1'b0;
  logic [7:0]  statusDataIn = 8'h00;
  logic        cmdArrayWrite = 1'b0;
  logic [12:0] writeAddr = 13'h0;
  logic        wpN = 1'b1;
  logic        engineBusy = 1'b0;
  logic [7:0]  statusByte, statusByte12;
  logic        arrayWritePermit, statusWritePermit;
  logic        arrayWritePermit12, statusWritePermit12;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  eeprom_status_guard #(.ADDR_W(13)) u_dut (
    .clk(clk), .rstN(rstN), .cmdSetEnable(cmdSetEnable), .cmdClearEnable(cmdClearEnable),
    .cmdStatusWrite(cmdStatusWrite), .statusDataIn(statusDataIn), .cmdArrayWrite(cmdArrayWrite),
    .writeAddr(writeAddr), .wpN(wpN), .engineBusy(engineBusy), .statusByte(statusByte),
    .arrayWritePermit(arrayWritePermit), .statusWritePermit(statusWritePermit));

  eeprom_status_guard #(.ADDR_W(12)) u_dut12 (
    .clk(clk), .rstN(rstN), .cmdSetEnable(cmdSetEnable), .cmdClearEnable(cmdClearEnable),
    .cmdStatusWrite(cmdStatusWrite), .statusDataIn(statusDataIn), .cmdArrayWrite(cmdArrayWrite),
    .writeAddr(writeAddr[11:0]), .wpN(wpN), .engineBusy(engineBusy), .statusByte(statusByte12),
    .arrayWritePermit(arrayWritePermit12), .statusWritePermit(statusWritePermit12));

  // op: 0 none, 1 set-enable, 2 clear-enable, 3 status write, 4 array write
  // fields: op, data, addr, wpN, busy, expArray, expStatusPermit, expStatus
  localparam int NVEC = 32;
  localparam logic [38:0] VEC [NVEC] = '{
    {3'd4, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // R4 no latch
    {3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h02}, // R2
    {3'd4, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00}, // R4 R3
    {3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h02},
    {3'd3, 8'hFF, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 8'h8C}, // R6 R1 junk bits
    {3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h8E},
    {3'd4, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h8C}, // R5 whole, R3
    {3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h8E},
    {3'd3, 8'h84, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 8'h84}, // R6
    {3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h86},
    {3'd4, 8'h00, 16'h17FF, 1'b1, 1'b0, 1'b1, 1'b0, 8'h84}, // R5 quarter edge
    {3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h86},
    {3'd4, 8'h00, 16'h1800, 1'b1, 1'b0, 1'b0, 1'b0, 8'h84}, // R5 quarter start
    {3'd1, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h86},
    {3'd3, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h84}, // R7 locked
    {3'd1, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h86},
    {3'd4, 8'h00, 16'h0100, 1'b0, 1'b0, 1'b1, 1'b0, 8'h84}, // R7 pin ignored by array
    {3'd1, 8'h00, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h85}, // R8
    {3'd0, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h84},
    {3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h86},
    {3'd2, 8'h00, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h87}, // R8
    {3'd3, 8'h00, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h87}, // R8
    {3'd4, 8'h00, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h87}, // R8
    {3'd2, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h84}, // R3
    {3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h86},
    {3'd3, 8'h08, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 8'h08}, // R6
    {3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0A},
    {3'd4, 8'h00, 16'h0FFF, 1'b1, 1'b0, 1'b1, 1'b0, 8'h08}, // R5 half edge
    {3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0A},
    {3'd4, 8'h00, 16'h1000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h08}, // R5 half start
    {3'd1, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0A},
    {3'd3, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00}  // R7 unlocked lock bit
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [7:0] d, input logic [12:0] a,
                       input logic wp, input logic busy);
    cmdSetEnable   = (op == 3'd1);
    cmdClearEnable = (op == 3'd2);
    cmdStatusWrite = (op == 3'd3);
    cmdArrayWrite  = (op == 3'd4);
    statusDataIn   = d;
    writeAddr      = a;
    wpN            = wp;
    engineBusy     = busy;
  endtask

  task automatic idleCycle();
    @(negedge clk);
    drive(3'd0, 8'h00, 13'h0, 1'b1, 1'b0);
    @(posedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset status", statusByte, 8'h00);
    check("R9 reset permits", {6'd0, arrayWritePermit, statusWritePermit}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VEC[i][38:36], VEC[i][35:28], VEC[i][24:12], VEC[i][11], VEC[i][10]);
      #1;
      check($sformatf("R4 array permit vec %0d", i), {7'd0, arrayWritePermit}, {7'd0, VEC[i][9]});
      check($sformatf("R6 status permit vec %0d", i), {7'd0, statusWritePermit}, {7'd0, VEC[i][8]});
      @(posedge clk);
      #1;
      check($sformatf("R1 status vec %0d", i), statusByte, VEC[i][7:0]);
    end

    // R3: clear wins over set in one cycle
    @(negedge clk); drive(3'd1, 8'h00, 13'h0, 1'b1, 1'b0);
    @(posedge clk);
    @(negedge clk); drive(3'd2, 8'h00, 13'h0, 1'b1, 1'b0); cmdSetEnable = 1'b1;
    @(posedge clk); #1;
    check("R3 clear beats set", statusByte, 8'h00);

    // R5 with 12-bit address: set quarter protection in both instances
    @(negedge clk); drive(3'd1, 8'h00, 13'h0, 1'b1, 1'b0);
    @(posedge clk);
    @(negedge clk); drive(3'd3, 8'h04, 13'h0, 1'b1, 1'b0);
    @(posedge clk); #1;
    check("R5 12-bit status", statusByte12, 8'h04);
    @(negedge clk); drive(3'd1, 8'h00, 13'h0, 1'b1, 1'b0);
    @(posedge clk);
    @(negedge clk); drive(3'd4, 8'h00, 13'h0BFF, 1'b1, 1'b0);
    #0.5;
    check("R5 12-bit 0BFF open", {7'd0, arrayWritePermit12}, 8'h01);
    writeAddr = 13'h0C00;
    #0.5;
    check("R5 12-bit 0C00 locked", {7'd0, arrayWritePermit12}, 8'h00);
    check("R5 13-bit 0C00 open", {7'd0, arrayWritePermit}, 8'h01);
    @(posedge clk); #1;
    check("R3 latch cleared after write", statusByte12, 8'h04);

    // R9 reset mid-run clears everything
    idleCycle();
    @(negedge clk); drive(3'd1, 8'h00, 13'h0, 1'b1, 1'b0);
    @(posedge clk);
    @(negedge clk); drive(3'd0, 8'h00, 13'h0, 1'b1, 1'b0); rstN = 1'b0;
    #1;
    check("R9 mid-run reset", statusByte, 8'h00);
    @(negedge clk); rstN = 1'b1;
    idleCycle();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule